// File: doc/BRIEF.md
# Shared Engine Ownership Arbiter

This block decides which of several serial-port clients may use one shared direct-memory-access engine. The engine has a receive channel and a transmit channel, and each channel is arbitrated on its own. Every client sees one small register per channel through its own register port. Bit 0 of that register is the client's request flag. Bit 1 is a read-only flag that shows whether the client currently holds that channel.

A client owns the engine only while it holds both channels. The block reports this on a per-client ownership output. Ownership is exclusive and never taken away: a holder keeps a channel for as long as its request flag stays set. Other clients may leave their requests set meanwhile. Those requests wait and are served when the channel becomes free. When several clients ask for a free channel in the same cycle, the lowest-numbered client wins.

Top module: `shared_engine_arb`

## Requirements
- R1: Each client has two registers. The receive register is at byte offset 0x00 and the transmit register at byte offset 0x04. A read returns the request flag in bit 0, the grant flag in bit 1 and zero in every other bit.
- R2: A write to a channel register loads the request flag from write-data bit 0. Write-data bit 1 does not change the grant flag. A write to any other offset changes nothing, and a read of any other offset returns zero.
- R3: The ownership output of a client is 1 exactly when that client holds the grant of both the receive and the transmit channel.
- R4: At most one client holds the grant of a given channel at any time.
- R5: A holder keeps its grant while its request flag stays set. Requests from other clients stay ungranted during that time.
- R6: A request written to an idle channel is visible in the cycle after the write, and its grant follows one clock later.
- R7: When several clients request an idle channel in the same cycle, the lowest-numbered client is granted.
- R8: The grant falls in the same cycle that the holder's request flag clears. A waiting request is granted one clock later.
- R9: A waiting request that is cleared before the channel becomes free is never granted.
- R10: After reset every request flag and every grant flag is zero, and no client owns the engine.
- R11: The two channels are arbitrated independently. A client can hold one channel while another client holds the other, and then neither client owns the engine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | N_CLIENTS | Write strobe, one bit per client |
| reg_addr | input | N_CLIENTS*ADDR_W | Byte offset for each client's register port |
| reg_wdata | input | N_CLIENTS*DATA_W | Write data, one word per client |
| reg_rdata | output | N_CLIENTS*DATA_W | Read data for the offset on each client's address field |
| owner | output | N_CLIENTS | High while that client holds both channels |

## Verification
The hardest case to reach is the one where the two channels are held by different clients. Both channels must be idle, and then requests from different clients must land in the same cycle on one channel and in a different combination on the other. The stimulus first releases every holder. It then writes the receive registers of clients 1 and 2 together, and the transmit registers of clients 0 and 2 together. This splits the engine and leaves client 2 waiting on both channels. Finally one holder is released, and the bench checks that the waiting client is handed that channel but still does not own the engine.

// File: rtl/shared_engine_arb_pkg.sv
`timescale 1ns/1ps
package shared_engine_arb_pkg;
   localparam int unsigned OFS_RX  = 0;
   localparam int unsigned OFS_TX  = 4;
   localparam int unsigned BIT_REQ = 0;
   localparam int unsigned BIT_GNT = 1;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_RX   = 2'd1,
      SEL_TX   = 2'd2
   } reg_sel_e;
endpackage

// File: rtl/arb_prio_pick.sv
`timescale 1ns/1ps
// Fixed-priority one-hot picker; LOW_FIRST selects which end wins.
module arb_prio_pick #(
   parameter int unsigned N         = 3,
   parameter bit          LOW_FIRST = 1'b1
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] pick
);
   logic [N:0] seen;
   assign seen[0] = 1'b0;

   generate
      if (LOW_FIRST) begin : g_low
         for (genvar i = 0; i < N; i++) begin : g_bit
            assign pick[i]   = req[i] & ~seen[i];
            assign seen[i+1] = seen[i] | req[i];
         end
      end else begin : g_high
         for (genvar i = 0; i < N; i++) begin : g_bit
            assign pick[N-1-i] = req[N-1-i] & ~seen[i];
            assign seen[i+1]   = seen[i] | req[N-1-i];
         end
      end
   endgenerate
endmodule

// File: rtl/arb_chan.sv
`timescale 1ns/1ps
// One channel: request flags for all clients plus the held grant.
module arb_chan #(
   parameter int unsigned N         = 3,
   parameter bit          LOW_FIRST = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] wr_en,
   input  logic [N-1:0] wr_bit,
   output logic [N-1:0] req_o,
   output logic [N-1:0] gnt_o
);
   logic [N-1:0] req_q;
   logic [N-1:0] gnt_q;
   logic [N-1:0] gnt_live;
   logic [N-1:0] pick;
   logic         busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q <= '0;
      else        req_q <= (req_q & ~wr_en) | (wr_en & wr_bit);
   end

   // A grant only counts while its owner still requests.
   assign gnt_live = gnt_q & req_q;
   assign busy     = |gnt_live;

   arb_prio_pick #(.N(N), .LOW_FIRST(LOW_FIRST)) u_pick (
      .req  (req_q),
      .pick (pick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     gnt_q <= '0;
      else if (!busy) gnt_q <= pick;
   end

   assign req_o = req_q;
   assign gnt_o = gnt_live;
endmodule

// File: rtl/arb_regif.sv
`timescale 1ns/1ps
// Per-client register decode and read mux.
module arb_regif
   import shared_engine_arb_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 4
) (
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rx_req,
   input  logic              rx_gnt,
   input  logic              tx_req,
   input  logic              tx_gnt,
   output logic              rx_wr,
   output logic              tx_wr,
   output logic              wbit,
   output logic [DATA_W-1:0] rdata
);
   localparam logic [ADDR_W-1:0] A_RX = ADDR_W'(OFS_RX);
   localparam logic [ADDR_W-1:0] A_TX = ADDR_W'(OFS_TX);

   reg_sel_e sel;
   logic     unused_wdata;

   always_comb begin
      if (addr == A_RX)      sel = SEL_RX;
      else if (addr == A_TX) sel = SEL_TX;
      else                   sel = SEL_NONE;
   end

   assign rx_wr        = wr && (sel == SEL_RX);
   assign tx_wr        = wr && (sel == SEL_TX);
   assign wbit         = wdata[BIT_REQ];
   assign unused_wdata = ^wdata;

   always_comb begin
      rdata = '0;
      unique case (sel)
         SEL_RX: begin
            rdata[BIT_REQ] = rx_req;
            rdata[BIT_GNT] = rx_gnt;
         end
         SEL_TX: begin
            rdata[BIT_REQ] = tx_req;
            rdata[BIT_GNT] = tx_gnt;
         end
         default: rdata = '0;
      endcase
   end
endmodule

// File: rtl/shared_engine_arb.sv
`timescale 1ns/1ps
module shared_engine_arb #(
   parameter int unsigned N_CLIENTS = 3,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ADDR_W    = 4,
   parameter bit          LOW_FIRST = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [N_CLIENTS-1:0]          reg_wr,
   input  logic [N_CLIENTS*ADDR_W-1:0]   reg_addr,
   input  logic [N_CLIENTS*DATA_W-1:0]   reg_wdata,
   output logic [N_CLIENTS*DATA_W-1:0]   reg_rdata,
   output logic [N_CLIENTS-1:0]          owner
);
   generate
      if (N_CLIENTS < 2) begin : g_chk_n
         $error("shared_engine_arb: N_CLIENTS must be at least 2");
      end
      if (DATA_W < 2) begin : g_chk_dw
         $error("shared_engine_arb: DATA_W must hold request and grant bits");
      end
      if (ADDR_W < 3) begin : g_chk_aw
         $error("shared_engine_arb: ADDR_W must reach the transmit offset");
      end
   endgenerate

   logic [N_CLIENTS-1:0] rx_wr;
   logic [N_CLIENTS-1:0] tx_wr;
   logic [N_CLIENTS-1:0] wbit;
   logic [N_CLIENTS-1:0] rx_req;
   logic [N_CLIENTS-1:0] rx_gnt;
   logic [N_CLIENTS-1:0] tx_req;
   logic [N_CLIENTS-1:0] tx_gnt;

   generate
      for (genvar c = 0; c < N_CLIENTS; c++) begin : g_client
         arb_regif #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_if (
            .wr     (reg_wr[c]),
            .addr   (reg_addr[c*ADDR_W +: ADDR_W]),
            .wdata  (reg_wdata[c*DATA_W +: DATA_W]),
            .rx_req (rx_req[c]),
            .rx_gnt (rx_gnt[c]),
            .tx_req (tx_req[c]),
            .tx_gnt (tx_gnt[c]),
            .rx_wr  (rx_wr[c]),
            .tx_wr  (tx_wr[c]),
            .wbit   (wbit[c]),
            .rdata  (reg_rdata[c*DATA_W +: DATA_W])
         );
      end
   endgenerate

   arb_chan #(.N(N_CLIENTS), .LOW_FIRST(LOW_FIRST)) u_rx (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (rx_wr),
      .wr_bit (wbit),
      .req_o  (rx_req),
      .gnt_o  (rx_gnt)
   );

   arb_chan #(.N(N_CLIENTS), .LOW_FIRST(LOW_FIRST)) u_tx (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (tx_wr),
      .wr_bit (wbit),
      .req_o  (tx_req),
      .gnt_o  (tx_gnt)
   );

   assign owner = rx_gnt & tx_gnt;
endmodule

// File: rtl/shared_engine_arb_chk.sv
`timescale 1ns/1ps
module shared_engine_arb_chk #(
   parameter int unsigned N         = 3,
   parameter bit          LOW_FIRST = 1'b1
) (
   input logic         clk,
   input logic         rst_n,
   input logic [N-1:0] rx_req,
   input logic [N-1:0] rx_gnt,
   input logic [N-1:0] tx_req,
   input logic [N-1:0] tx_gnt,
   input logic [N-1:0] owner
);
   logic [1:0][N-1:0] req_a;
   logic [1:0][N-1:0] gnt_a;
   assign req_a = {tx_req, rx_req};
   assign gnt_a = {tx_gnt, rx_gnt};

   generate
      for (genvar ch = 0; ch < 2; ch++) begin : g_ch
         p_single_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(gnt_a[ch]));
         for (genvar i = 0; i < N; i++) begin : g_cl
            p_keep_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
               gnt_a[ch][i] |=> (gnt_a[ch][i] || !req_a[ch][i]));
            p_grant_from_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
               $rose(gnt_a[ch][i]) |-> ($past(req_a[ch][i]) && ($past(gnt_a[ch]) == '0)));
            if (LOW_FIRST) begin : g_pri
               for (genvar j = 0; j < i; j++) begin : g_lower
                  p_lowest_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
                     $rose(gnt_a[ch][i]) |-> !$past(req_a[ch][j]));
               end
            end
         end
      end
      for (genvar i = 0; i < N; i++) begin : g_own
         p_owner_requests_r3: assert property (@(posedge clk) disable iff (!rst_n)
            owner[i] |-> (rx_req[i] && tx_req[i]));
      end
   endgenerate
endmodule

bind shared_engine_arb shared_engine_arb_chk #(.N(N_CLIENTS), .LOW_FIRST(LOW_FIRST)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .rx_req (rx_req),
   .rx_gnt (rx_gnt),
   .tx_req (tx_req),
   .tx_gnt (tx_gnt),
   .owner  (owner)
);

// File: tb/shared_engine_arb_tb.sv
`timescale 1ns/1ps
module shared_engine_arb_tb;
   localparam int N  = 3;
   localparam int DW = 32;
   localparam int AW = 4;
   localparam int RX = 0;
   localparam int TX = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [N-1:0]    reg_wr = '0;
   logic [N*AW-1:0] reg_addr = '0;
   logic [N*DW-1:0] reg_wdata = '0;
   logic [N*DW-1:0] reg_rdata;
   logic [N-1:0]    owner;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   shared_engine_arb #(.N_CLIENTS(N), .DATA_W(DW), .ADDR_W(AW)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .owner     (owner)
   );

   typedef struct {
      int          cl;
      int          ofs;
      logic [31:0] exp;
      logic [N-1:0] own;
      string       tag;
   } item_t;

   item_t q[$];
   event  ev;

   // Monitor: pops expected items and compares against the ports.
   always begin
      item_t       it;
      logic [31:0] got;
      @(ev);
      while (q.size() > 0) begin
         it  = q.pop_front();
         got = reg_rdata[it.cl*DW +: DW];
         checks++;
         if (got !== it.exp || owner !== it.own) begin
            errors++;
            $display("FAIL %s: client %0d ofs %0h rdata %h owner %b, expected rdata %h owner %b",
                     it.tag, it.cl, it.ofs, got, owner, it.exp, it.own);
         end
      end
   end

   task automatic wr(input int cl, input int ofs, input logic [31:0] d);
      @(negedge clk);
      reg_wr[cl] = 1'b1;
      reg_addr[cl*AW +: AW] = AW'(ofs);
      reg_wdata[cl*DW +: DW] = d;
      @(negedge clk);
      reg_wr = '0;
   endtask

   task automatic wr_multi(input logic [N-1:0] mask, input int ofs, input logic [31:0] d);
      @(negedge clk);
      for (int c = 0; c < N; c++) begin
         if (mask[c]) begin
            reg_wr[c] = 1'b1;
            reg_addr[c*AW +: AW] = AW'(ofs);
            reg_wdata[c*DW +: DW] = d;
         end
      end
      @(negedge clk);
      reg_wr = '0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Driver side: set the read offset, then push the expectation.
   task automatic chk(input int cl, input int ofs, input logic [31:0] e,
                      input logic [N-1:0] own, input string tag);
      item_t it;
      reg_addr[cl*AW +: AW] = AW'(ofs);
      #0.2;
      it.cl = cl; it.ofs = ofs; it.exp = e; it.own = own; it.tag = tag;
      q.push_back(it);
      -> ev;
      #0.2;
   endtask

   initial begin
      #(20 * 20000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk(0, RX, 0, 3'b000, "R10 reset rx");
      chk(1, TX, 0, 3'b000, "R10 reset tx");
      chk(2, RX, 0, 3'b000, "R10 reset rx c2");

      wr(0, RX, 1);
      chk(0, RX, 1, 3'b000, "R6 request visible, grant pending");
      idle(1);
      chk(0, RX, 3, 3'b000, "R6 grant one clock later");
      chk(0, TX, 0, 3'b000, "R11 rx alone gives no ownership");

      wr(0, TX, 1);
      idle(1);
      chk(0, TX, 3, 3'b001, "R3 both grants give ownership");
      chk(0, RX, 3, 3'b001, "R1 readback request and grant");

      wr(1, RX, 1);
      wr(1, TX, 1);
      wr(2, TX, 1);
      idle(2);
      chk(1, RX, 1, 3'b001, "R5 other rx request waits");
      chk(1, TX, 1, 3'b001, "R5 other tx request waits");
      chk(2, TX, 1, 3'b001, "R5 third request waits");
      chk(0, RX, 3, 3'b001, "R5 holder keeps grant");

      wr(2, TX, 0);
      chk(2, TX, 0, 3'b001, "R9 withdrawn request");

      wr(0, RX, 0);
      chk(0, RX, 0, 3'b000, "R8 grant falls with request");
      chk(1, RX, 1, 3'b000, "R8 waiter not yet granted");
      idle(1);
      chk(1, RX, 3, 3'b000, "R8 waiter granted next clock");
      chk(0, TX, 3, 3'b000, "R11 split ownership");

      wr(0, TX, 0);
      chk(0, TX, 0, 3'b000, "R8 tx grant falls");
      idle(1);
      chk(1, TX, 3, 3'b010, "R8 tx waiter granted");
      chk(2, TX, 0, 3'b010, "R9 withdrawn never granted");

      wr(2, RX, 32'h2);
      chk(2, RX, 0, 3'b010, "R2 grant bit not writable");
      wr(2, 8, 32'h1);
      idle(1);
      chk(2, 8, 0, 3'b010, "R2 other offset reads zero");
      chk(2, RX, 0, 3'b010, "R2 other offset no rx effect");
      chk(2, TX, 0, 3'b010, "R2 other offset no tx effect");

      wr(1, RX, 32'hFFFF_FFFF);
      idle(1);
      chk(1, RX, 3, 3'b010, "R1 upper bits read zero");

      wr(1, RX, 0);
      wr(1, TX, 0);
      idle(1);
      chk(1, RX, 0, 3'b000, "R8 release both");

      wr_multi(3'b110, RX, 1);
      idle(1);
      chk(1, RX, 3, 3'b000, "R7 lowest rx requester wins");
      chk(2, RX, 1, 3'b000, "R7 higher rx requester waits");

      wr_multi(3'b101, TX, 1);
      idle(1);
      chk(0, TX, 3, 3'b000, "R7 lowest tx requester wins");
      chk(2, TX, 1, 3'b000, "R11 channels split, no owner");

      wr(1, RX, 0);
      idle(1);
      chk(2, RX, 3, 3'b000, "R8 waiting rx granted after release");
      chk(2, TX, 1, 3'b000, "R11 still no owner");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule